// File: doc/BRIEF.md
# Flash Write-Command Unlock Sequencer

This block sits between a byte-wide flash bus interface and the array controller. It watches every accepted host write, given as an address, a data byte and a one-cycle write-valid pulse, and tracks the keyed multi-cycle unlock sequences that must come before any program or erase. A write that does not fit the expected next step drops the tracker back to idle. A later attempt must then begin the full sequence again.

When a sequence completes, the block issues a single-cycle start pulse toward the array controller. A byte program is announced on `prog_start`, with its target address and data. An erase is announced on `erase_start`, with an erase kind and the address already aligned to the erased region. Short three-cycle sequences switch the read path between normal array reads, identification reads and parameter-query reads. While identification reads are selected, the block supplies the vendor and device code bytes itself. A busy input from the array controller freezes the whole tracker, so that writes arriving during an internal operation have no effect.

Top module: `unlock_seq`

## Requirements
- R1: After reset, `read_mode` is 0 (array), `prog_start` and `erase_start` are low, and `id_data` is 00h.
- R2: The writes AAh to key address A (5555h), 55h to key address B (2AAAh) and A0h to key address A, followed by a fourth write, make `prog_start` high for the cycle after that fourth write. At the same time, `op_addr` and `op_data` carry the fourth write's address and data. Key addresses are compared on address bits 14..0 only.
- R3: The six-write erase sequence is the prefix AAh@A, 55h@B, 80h@A, then AAh@A, 55h@B, then a last write. If that last write carries 30h, `erase_start` pulses with `erase_kind` = 2, and `op_addr` is the last write's address with bits 11..0 cleared.
- R4: If the last erase write carries 50h, `erase_start` pulses with `erase_kind` = 3, and `op_addr` is that address with bits 15..0 cleared.
- R5: If the last erase write carries 10h at key address A, `erase_start` pulses with `erase_kind` = 1. A 10h last write at any other address starts nothing.
- R6: The prefix AAh@A, 55h@B, 90h@A sets `read_mode` to 1 (identification). In that mode, `id_data` is BFh when `rd_addr` is 0, the device code (D8h by default) when `rd_addr` is 1, and 00h for any other address.
- R7: The prefix AAh@A, 55h@B, 98h@A sets `read_mode` to 2 (query). `id_data` is 00h whenever `read_mode` is not 1.
- R8: `read_mode` returns to 0 on either of two exits: a single F0h write to any address while no sequence is in progress, or F0h written to key address A as the third cycle of the prefix.
- R9: A write that does not match the expected step returns the tracker to idle. Writes that would have completed the abandoned sequence start nothing, and a complete sequence afterwards works normally.
- R10: A write presented while `busy` is high is ignored. The sequence position and `read_mode` are unchanged, and no start pulse follows.
- R11: `prog_start` and `erase_start` are never high together, each lasts exactly one cycle, and each follows an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | One-cycle pulse marking an accepted host write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Array controller is executing an internal operation |
| rd_addr | input | ADDR_W | Current read address for identification data |
| prog_start | output | 1 | One-cycle byte-program request |
| erase_start | output | 1 | One-cycle erase request |
| erase_kind | output | 2 | 1 chip, 2 sector, 3 block (0 after reset) |
| op_addr | output | ADDR_W | Target address of the last request |
| op_data | output | 8 | Data of the last request's final write |
| read_mode | output | 2 | 0 array, 1 identification, 2 query |
| id_data | output | 8 | Identification read data |

## Verification
The bench builds the block with a 20-bit address, a 15-bit key compare, sector alignment at bit 12, block alignment at bit 16 and device code D8h. Because the address is wider than the key compare, the bench can drive key cycles whose upper address bits are set, which tests the aliasing rule. The chosen addresses also leave bits set both below and above the two alignment points, so a mask at the wrong position produces a visibly wrong `op_addr`.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_K1,
        SQ_K2,
        SQ_PROG,
        SQ_E3,
        SQ_E4,
        SQ_E5
    } seq_state_e;

    typedef enum logic [1:0] {
        RM_ARRAY = 2'd0,
        RM_ID    = 2'd1,
        RM_CFI   = 2'd2
    } read_mode_e;

    typedef enum logic [1:0] {
        EK_NONE   = 2'd0,
        EK_CHIP   = 2'd1,
        EK_SECTOR = 2'd2,
        EK_BLOCK  = 2'd3
    } erase_kind_e;

    localparam logic [7:0] KEY1_DATA  = 8'hAA;
    localparam logic [7:0] KEY2_DATA  = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_ID     = 8'h90;
    localparam logic [7:0] CMD_CFI    = 8'h98;
    localparam logic [7:0] CMD_EXIT   = 8'hF0;
    localparam logic [7:0] ERS_CHIP   = 8'h10;
    localparam logic [7:0] ERS_SECTOR = 8'h30;
    localparam logic [7:0] ERS_BLOCK  = 8'h50;

endpackage

// File: rtl/unlock_cycle_match.sv
module unlock_cycle_match
    import unlock_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int KEY_W  = 15,
    parameter logic [KEY_W-1:0] KEY_A = 15'h5555,
    parameter logic [KEY_W-1:0] KEY_B = 15'h2AAA
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              key1_hit,
    output logic              key2_hit,
    output logic              cmd_addr_hit
);
    logic [KEY_W-1:0] low_addr;

    always_comb begin
        low_addr     = addr[KEY_W-1:0];
        cmd_addr_hit = (low_addr == KEY_A);
        key1_hit     = cmd_addr_hit && (data == KEY1_DATA);
        key2_hit     = (low_addr == KEY_B) && (data == KEY2_DATA);
    end
endmodule

// File: rtl/unlock_addr_align.sv
module unlock_addr_align #(
    parameter int ADDR_W = 20,
    parameter int LSB    = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] aligned
);
    generate
        if (LSB <= 0) begin : g_pass
            assign aligned = addr;
        end else if (LSB >= ADDR_W) begin : g_zero
            assign aligned = '0;
        end else begin : g_mask
            assign aligned = {addr[ADDR_W-1:LSB], {LSB{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/unlock_id_mux.sv
module unlock_id_mux
    import unlock_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter logic [7:0] MFR_CODE = 8'hBF,
    parameter logic [7:0] DEV_CODE = 8'hD8
) (
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        id_data
);
    always_comb begin
        id_data = 8'h00;
        if (mode == RM_ID) begin
            if (rd_addr == ADDR_W'(0))
                id_data = MFR_CODE;
            else if (rd_addr == ADDR_W'(1))
                id_data = DEV_CODE;
        end
    end
endmodule

// File: rtl/unlock_seq.sv
module unlock_seq
    import unlock_seq_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int KEY_W      = 15,
    parameter int SECTOR_LSB = 12,
    parameter int BLOCK_LSB  = 16,
    parameter logic [7:0] MFR_CODE = 8'hBF,
    parameter logic [7:0] DEV_CODE = 8'hD8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prog_start,
    output logic              erase_start,
    output logic [1:0]        erase_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic [1:0]        read_mode,
    output logic [7:0]        id_data
);
    localparam logic [KEY_W-1:0]  KEY_A     = KEY_W'(15'h5555);
    localparam logic [KEY_W-1:0]  KEY_B     = KEY_W'(15'h2AAA);
    localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((64'd1 << SECTOR_LSB) - 64'd1);
    localparam logic [ADDR_W-1:0] BLK_MASK  = ADDR_W'((64'd1 << BLOCK_LSB) - 64'd1);

    typedef struct packed {
        seq_state_e        st;
        read_mode_e        mode;
        logic              prog;
        logic              ers;
        erase_kind_e       kind;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              key1_hit, key2_hit, cmd_addr_hit;
    logic [ADDR_W-1:0] sector_addr, block_addr;
    logic              accept;

    unlock_cycle_match #(
        .ADDR_W(ADDR_W), .KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)
    ) u_match (
        .addr(wr_addr), .data(wr_data),
        .key1_hit(key1_hit), .key2_hit(key2_hit), .cmd_addr_hit(cmd_addr_hit)
    );

    unlock_addr_align #(.ADDR_W(ADDR_W), .LSB(SECTOR_LSB)) u_sect_align (
        .addr(wr_addr), .aligned(sector_addr)
    );

    unlock_addr_align #(.ADDR_W(ADDR_W), .LSB(BLOCK_LSB)) u_blk_align (
        .addr(wr_addr), .aligned(block_addr)
    );

    unlock_id_mux #(
        .ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
    ) u_id_mux (
        .mode(r_q.mode), .rd_addr(rd_addr), .id_data(id_data)
    );

    assign accept = wr_valid && !busy;

    always_comb begin
        r_d      = r_q;
        r_d.prog = 1'b0;
        r_d.ers  = 1'b0;
        if (accept) begin
            case (r_q.st)
                SQ_IDLE: begin
                    if (key1_hit)
                        r_d.st = SQ_K1;
                    else if (wr_data == CMD_EXIT)
                        r_d.mode = RM_ARRAY;
                end
                SQ_K1: r_d.st = key2_hit ? SQ_K2 : SQ_IDLE;
                SQ_K2: begin
                    r_d.st = SQ_IDLE;
                    if (cmd_addr_hit) begin
                        case (wr_data)
                            CMD_PROG:  r_d.st   = SQ_PROG;
                            CMD_ERASE: r_d.st   = SQ_E3;
                            CMD_ID:    r_d.mode = RM_ID;
                            CMD_CFI:   r_d.mode = RM_CFI;
                            CMD_EXIT:  r_d.mode = RM_ARRAY;
                            default:   r_d.st   = SQ_IDLE;
                        endcase
                    end
                end
                SQ_PROG: begin
                    r_d.st   = SQ_IDLE;
                    r_d.prog = 1'b1;
                    r_d.addr = wr_addr;
                    r_d.data = wr_data;
                end
                SQ_E3: r_d.st = key1_hit ? SQ_E4 : SQ_IDLE;
                SQ_E4: r_d.st = key2_hit ? SQ_E5 : SQ_IDLE;
                SQ_E5: begin
                    r_d.st = SQ_IDLE;
                    if (wr_data == ERS_CHIP && cmd_addr_hit) begin
                        r_d.ers  = 1'b1;
                        r_d.kind = EK_CHIP;
                        r_d.addr = wr_addr;
                        r_d.data = wr_data;
                    end else if (wr_data == ERS_SECTOR) begin
                        r_d.ers  = 1'b1;
                        r_d.kind = EK_SECTOR;
                        r_d.addr = sector_addr;
                        r_d.data = wr_data;
                    end else if (wr_data == ERS_BLOCK) begin
                        r_d.ers  = 1'b1;
                        r_d.kind = EK_BLOCK;
                        r_d.addr = block_addr;
                        r_d.data = wr_data;
                    end
                end
                default: r_d.st = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= SQ_IDLE;
            r_q.mode <= RM_ARRAY;
            r_q.prog <= 1'b0;
            r_q.ers  <= 1'b0;
            r_q.kind <= EK_NONE;
            r_q.addr <= '0;
            r_q.data <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign prog_start  = r_q.prog;
    assign erase_start = r_q.ers;
    assign erase_kind  = r_q.kind;
    assign op_addr     = r_q.addr;
    assign op_data     = r_q.data;
    assign read_mode   = r_q.mode;

    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_start && erase_start)); // R11

    AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start || erase_start) |-> $past(wr_valid) && !$past(busy)); // R11

    AST_PROG_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> (op_data == $past(wr_data)) && (op_addr == $past(wr_addr))); // R2

    AST_SECTOR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_start && erase_kind == EK_SECTOR) |-> ((op_addr & SECT_MASK) == '0)); // R3

    AST_BLOCK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_start && erase_kind == EK_BLOCK) |-> ((op_addr & BLK_MASK) == '0)); // R4

    AST_ERASE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> erase_kind != EK_NONE); // R3

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(read_mode) && !prog_start && !erase_start); // R10

    AST_ID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        read_mode != RM_ID |-> id_data == 8'h00); // R7

endmodule

// File: tb/unlock_seq_test.sv
module unlock_seq_test;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          busy = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          prog_start, erase_start;
    logic [1:0]    erase_kind, read_mode;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_data, id_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0]    kind;   // 0 program, 1 chip, 2 sector, 3 block
        logic [AW-1:0] addr;
        logic [7:0]    data;
        string         tag;
    } exp_t;

    exp_t pending[$];

    always #10 clk = ~clk;

    unlock_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr),
        .prog_start(prog_start), .erase_start(erase_start),
        .erase_kind(erase_kind), .op_addr(op_addr), .op_data(op_data),
        .read_mode(read_mode), .id_data(id_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every start pulse
    always @(negedge clk) begin
        if (rst_n && !done && (prog_start || erase_start)) begin
            chk(!(prog_start && erase_start), "R11 both starts", {prog_start, erase_start}, 32'h2);
            if (pending.size() == 0) begin
                chk(1'b0, "R11/R9 unexpected start", {erase_kind, op_addr}, 32'h0);
            end else begin
                exp_t e;
                e = pending.pop_front();
                if (e.kind == 0) begin
                    chk(prog_start, {e.tag, " prog_start"}, prog_start, 1);
                end else begin
                    chk(erase_start, {e.tag, " erase_start"}, erase_start, 1);
                    chk(erase_kind == e.kind[1:0], {e.tag, " erase_kind"}, erase_kind, e.kind);
                end
                chk(op_addr == e.addr, {e.tag, " op_addr"}, op_addr, e.addr);
                chk(op_data == e.data, {e.tag, " op_data"}, op_data, e.data);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic prefix(input logic [7:0] cmd);
        wr(20'h05555, 8'hAA);
        wr(20'h02AAA, 8'h55);
        wr(20'h05555, cmd);
    endtask

    task automatic push(input logic [2:0] k, input logic [AW-1:0] a, input logic [7:0] d, input string tag);
        exp_t e;
        e.kind = k; e.addr = a; e.data = d; e.tag = tag;
        pending.push_back(e);
    endtask

    task automatic erase_seq(input logic [AW-1:0] a, input logic [7:0] d);
        prefix(8'h80);
        wr(20'h05555, 8'hAA);
        wr(20'h02AAA, 8'h55);
        wr(a, d);
    endtask

    task automatic drained(input string tag);
        repeat (2) @(negedge clk);
        chk(pending.size() == 0, {tag, " pulses outstanding"}, pending.size(), 0);
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(read_mode == 0, "R1 read_mode", read_mode, 0);
        chk(!prog_start && !erase_start, "R1 starts", {prog_start, erase_start}, 0);
        chk(id_data == 8'h00, "R1 id_data", id_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: program, plain and with aliased upper key-address bits
        prefix(8'hA0);
        push(0, 20'h12345, 8'h3C, "R2");
        wr(20'h12345, 8'h3C);
        drained("R2");
        wr(20'hD5555, 8'hAA);
        wr(20'hF2AAA, 8'h55);
        wr(20'h85555, 8'hA0);
        push(0, 20'hFFFFF, 8'h00, "R2 alias");
        wr(20'hFFFFF, 8'h00);
        drained("R2 alias");

        // R3 / R4 / R5: erases
        push(2, 20'hAB000, 8'h30, "R3");
        erase_seq(20'hABCDE, 8'h30);
        drained("R3");
        push(3, 20'h70000, 8'h50, "R4");
        erase_seq(20'h7FFFF, 8'h50);
        drained("R4");
        push(1, 20'h05555, 8'h10, "R5");
        erase_seq(20'h05555, 8'h10);
        drained("R5");
        erase_seq(20'h01234, 8'h10);
        drained("R5 chip at wrong address");

        // R6: identification mode
        prefix(8'h90);
        chk(read_mode == 1, "R6 read_mode", read_mode, 1);
        rd_addr = 20'h00000; #1;
        chk(id_data == 8'hBF, "R6 vendor code", id_data, 8'hBF);
        rd_addr = 20'h00001; #1;
        chk(id_data == 8'hD8, "R6 device code", id_data, 8'hD8);
        rd_addr = 20'h00002; #1;
        chk(id_data == 8'h00, "R6 other address", id_data, 0);
        rd_addr = 20'h00000;
        // R8: single-cycle exit anywhere
        wr(20'h00042, 8'hF0);
        chk(read_mode == 0, "R8 single exit", read_mode, 0);
        #1;
        chk(id_data == 8'h00, "R7 id_data in array mode", id_data, 0);

        // R7: query mode, then R8 keyed exit
        prefix(8'h98);
        chk(read_mode == 2, "R7 read_mode", read_mode, 2);
        #1;
        chk(id_data == 8'h00, "R7 id_data in query mode", id_data, 0);
        prefix(8'hF0);
        chk(read_mode == 0, "R8 keyed exit", read_mode, 0);

        // R9: aborts
        wr(20'h05555, 8'hAA);
        wr(20'h02AAA, 8'h56);
        wr(20'h05555, 8'hA0);
        wr(20'h00100, 8'h99);
        drained("R9 bad second key");
        prefix(8'h80);
        wr(20'h05555, 8'hAA);
        wr(20'h02AAA, 8'h54);
        wr(20'h03000, 8'h30);
        drained("R9 bad erase key");
        wr(20'h05555, 8'hAA);
        wr(20'h02AAB, 8'h55);
        wr(20'h05555, 8'h90);
        chk(read_mode == 0, "R9 ID entry aborted", read_mode, 0);
        prefix(8'hA0);
        push(0, 20'h00200, 8'h5A, "R9 recovery");
        wr(20'h00200, 8'h5A);
        drained("R9 recovery");

        // R10: busy freezes everything
        busy = 1'b1;
        prefix(8'hA0);
        wr(20'h00300, 8'h11);
        prefix(8'h90);
        busy = 1'b0;
        drained("R10 busy program");
        chk(read_mode == 0, "R10 busy ID entry", read_mode, 0);
        wr(20'h05555, 8'hAA);
        wr(20'h02AAA, 8'h55);
        busy = 1'b1;
        wr(20'h00400, 8'h77);
        busy = 1'b0;
        wr(20'h05555, 8'hA0);
        push(0, 20'h00500, 8'h66, "R10 held position");
        wr(20'h00500, 8'h66);
        drained("R10 held position");

        // R11: back-to-back requests, each pulse single-cycle
        push(0, 20'h00600, 8'h01, "R11 first");
        prefix(8'hA0);
        wr(20'h00600, 8'h01);
        push(3, 20'h30000, 8'h50, "R11 second");
        erase_seq(20'h3ABCD, 8'h50);
        drained("R11");

        finish_up();
    end
endmodule